// File: doc/BRIEF.md
# Multi-Area External Bus Controller

This block turns single-beat read and write requests from an internal master into timed cycles on an external asynchronous memory bus of the SRAM/ROM kind. The top three bits of the 24-bit request address select one of eight areas. The block drives that area's active-low chip select and times the cycle from that area's own settings. These settings are bus width, two- or three-state access, programmed wait states, extension cycles before and after the strobe, use of an external wait pin, and an early read-strobe release.

The internal master raises `req` with an address, a direction and a width flag. It then waits for a one-clock `rdy` pulse, which arrives after the whole external transaction is over. Per-area settings are loaded through a narrow register write port between transactions. The external side consists of a 24-bit address, separate data-out and data-in buses with an output-enable, eight chip selects, read and write strobes, and the wait input.

Top module: `ext_bus_ctrl`

## Requirements
- R1: The area index is `req_addr[23:21]`. While a transaction is in progress exactly one chip select is low, `ext_cs_n[index]`, and it stays low without a gap until the transaction ends. All chip selects are high when the bus is idle.
- R2: A settings word has this layout: bit0 = 16-bit area, bit1 = three-state access, bits[4:2] = programmed waits, bit5 = wait pin enabled, bit6 = leading extension, bit7 = trailing extension, bit8 = early read release. In a 16-bit area a wide request is a single cycle on all 16 lines, and a byte request uses lines [7:0].
- R3: In an 8-bit area a wide request becomes two byte cycles. The first goes to the request address and carries or returns bits [7:0]. The second goes to that address plus one and carries or returns bits [15:8].
- R4: In a two-state area every byte cycle has CS low for 2 clocks, and the strobe is low for the second clock only. The programmed wait count and the wait pin have no effect.
- R5: In a three-state area every byte cycle has CS low for 3 + waits clocks, and the strobe is low for all of them except the first.
- R6: With the wait pin enabled in a three-state area, `ext_wait_n` is sampled at the end of the last programmed wait clock, or at the end of the second clock when waits is 0. Each clock that samples it low adds one more wait clock. With the pin disabled, its level has no effect.
- R7: A leading or trailing extension adds one clock before or after the strobe phase of each byte cycle. During that clock CS is low and RD and WR are high.
- R8: With early release set, RD goes high at the falling clock edge in the middle of the final access clock. Otherwise it goes high at the end of that clock.
- R9: Write data and `ext_doe` are driven while WR is low. Read data is captured at the clock edge that ends the final access clock. RD and WR are never low together, and each becomes low only after a clock in which CS was already low.
- R10: `rdy` is high for exactly one clock, the clock after the last bus clock. At that point `rdata` holds the assembled read data, and CS is high.
- R11: After reset every area is 16-bit and three-state, with 7 waits, the wait pin disabled, no extensions and normal RD release. A wide read therefore keeps CS low for 10 clocks.
- R12: A settings write takes effect only when the controller is idle and `req` is low. A write presented during a transaction is dropped, and the area keeps its old timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, accepted when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit request, 0 = byte |
| req_addr | input | 24 | Byte address, bits [23:21] select the area |
| req_wdata | input | 16 | Write data |
| rdy | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read result, valid with rdy |
| cfg_we | input | 1 | Settings write strobe |
| cfg_area | input | 3 | Area whose settings are written |
| cfg_data | input | 9 | Settings word, layout in R2 |
| ext_addr | output | 24 | External byte address |
| ext_cs_n | output | 8 | Active-low chip selects, one per area |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_doe | output | 1 | Data output enable |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |
| ext_wait_n | input | 1 | Active-low wait request |

## Verification
Most faults in the sequencer or the settings store change the number of clocks for which CS or a strobe is low, so the bench counts these clocks for every transaction. A wrong wait count, a lost extension or an extra state shows up in the first transaction that uses the affected area. A wrong beat counter or lane select shows up as a wrong second byte address or a wrong assembled `rdata` on the first split transfer. A fault in the half-cycle release flop shows up as one half-clock sample too many or too few of RD low. A settings write leaking through during a transaction is visible only in the next transaction to that area.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int WAIT_W = 3;

    // Per-area timing word (bit 0 is the LSB of the settings write port)
    typedef struct packed {
        logic              rd_early;
        logic              ext_post;
        logic              ext_pre;
        logic              wait_en;
        logic [WAIT_W-1:0] waits;
        logic              three;
        logic              wide;
    } area_cfg_t;

    localparam int CFG_W = $bits(area_cfg_t);

    localparam area_cfg_t CFG_RESET = '{
        rd_early: 1'b0,
        ext_post: 1'b0,
        ext_pre:  1'b0,
        wait_en:  1'b0,
        waits:    {WAIT_W{1'b1}},
        three:    1'b1,
        wide:     1'b1
    };

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3,
        ST_POST,
        ST_DONE
    } bus_st_t;

    function automatic logic st_strobe(bus_st_t s);
        return (s == ST_T2) || (s == ST_TW) || (s == ST_T3);
    endfunction

    function automatic logic st_on_bus(bus_st_t s);
        return (s != ST_IDLE) && (s != ST_DONE);
    endfunction

endpackage

// File: rtl/ebc_cfg_bank.sv
module ebc_cfg_bank
    import ebc_pkg::*;
#(
    parameter int AREAS = 8,
    localparam int IDX_W = $clog2(AREAS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  area_cfg_t        wr_cfg,
    input  logic [IDX_W-1:0] rd_idx,
    output area_cfg_t        rd_cfg
);

    area_cfg_t view [AREAS];

    generate
        for (genvar g = 0; g < AREAS; g++) begin : g_slot
            area_cfg_t slot;
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot <= CFG_RESET;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    slot <= wr_cfg;
                end
            end
            assign view[g] = slot;
        end
    endgenerate

    assign rd_cfg = view[rd_idx];

endmodule

// File: rtl/ebc_area_dec.sv
module ebc_area_dec #(
    parameter int AREAS = 8,
    localparam int IDX_W = $clog2(AREAS)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [AREAS-1:0] sel
);

    generate
        for (genvar g = 0; g < AREAS; g++) begin : g_sel
            assign sel[g] = (idx == IDX_W'(g));
        end
    endgenerate

endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
    import ebc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              split,
    input  logic              three,
    input  logic [WAIT_W-1:0] waits,
    input  logic              wait_en,
    input  logic              ext_pre,
    input  logic              ext_post,
    input  logic              ext_wait_n,
    output bus_st_t           st,
    output logic              beat,
    output logic              fin
);

    logic [WAIT_W-1:0] cnt, cnt_n;
    bus_st_t           st_n;
    logic              beat_n;
    logic              beat_end, after;
    logic              hold;

    assign hold = wait_en && !ext_wait_n;
    assign fin  = three ? (st == ST_T3) : (st == ST_T2);

    always_comb begin
        st_n     = st;
        cnt_n    = cnt;
        beat_n   = beat;
        beat_end = 1'b0;
        after    = 1'b0;
        case (st)
            ST_IDLE: begin
                if (start) begin
                    beat_n = 1'b0;
                    st_n   = ext_pre ? ST_PRE : ST_T1;
                end
            end
            ST_PRE:  st_n = ST_T1;
            ST_T1: begin
                st_n  = ST_T2;
                cnt_n = '0;
            end
            ST_T2: begin
                if (!three) begin
                    beat_end = 1'b1;
                end else if (waits != '0) begin
                    st_n  = ST_TW;
                    cnt_n = WAIT_W'(1);
                end else if (hold) begin
                    st_n = ST_TW;
                end else begin
                    st_n = ST_T3;
                end
            end
            ST_TW: begin
                if (cnt < waits) begin
                    cnt_n = cnt + WAIT_W'(1);
                end else if (!hold) begin
                    st_n = ST_T3;
                end
            end
            ST_T3:   beat_end = 1'b1;
            ST_POST: after = 1'b1;
            ST_DONE: st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase

        if (beat_end) begin
            if (ext_post) begin
                st_n = ST_POST;
            end else begin
                after = 1'b1;
            end
        end

        if (after) begin
            if (split && !beat) begin
                beat_n = 1'b1;
                st_n   = ext_pre ? ST_PRE : ST_T1;
            end else begin
                st_n = ST_DONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            beat <= 1'b0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            beat <= beat_n;
        end
    end

endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int AREAS  = 8,
    localparam int IDX_W = $clog2(AREAS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rdy,
    output logic [DATA_W-1:0] rdata,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_area,
    input  logic [CFG_W-1:0]  cfg_data,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [AREAS-1:0]  ext_cs_n,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    output logic              ext_doe,
    output logic [DATA_W-1:0] ext_dout,
    input  logic [DATA_W-1:0] ext_din,
    input  logic              ext_wait_n
);

    bus_st_t           st;
    logic              beat, fin;
    logic              accept, split, cut, strobe;
    logic [ADDR_W-1:0] a_addr;
    logic              a_we, a_wide;
    logic [DATA_W-1:0] a_wdata;
    logic [DATA_W-1:0] rdata_r;
    logic [IDX_W-1:0]  idx_req, idx_cur, idx_cfg;
    logic [AREAS-1:0]  sel_cur;
    area_cfg_t         cfg;

    assign accept  = req && (st == ST_IDLE);
    assign idx_req = req_addr[ADDR_W-1 -: IDX_W];
    assign idx_cur = a_addr[ADDR_W-1 -: IDX_W];
    assign idx_cfg = (st == ST_IDLE) ? idx_req : idx_cur;
    assign split   = a_wide && !cfg.wide;

    // Request latch
    always_ff @(posedge clk) begin
        if (rst) begin
            a_addr  <= '0;
            a_we    <= 1'b0;
            a_wide  <= 1'b0;
            a_wdata <= '0;
        end else if (accept) begin
            a_addr  <= req_addr;
            a_we    <= req_we;
            a_wide  <= req_wide;
            a_wdata <= req_wdata;
        end
    end

    ebc_cfg_bank #(.AREAS(AREAS)) i_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we && (st == ST_IDLE) && !req),
        .wr_idx (cfg_area),
        .wr_cfg (area_cfg_t'(cfg_data)),
        .rd_idx (idx_cfg),
        .rd_cfg (cfg)
    );

    ebc_area_dec #(.AREAS(AREAS)) i_dec (
        .idx (idx_cur),
        .sel (sel_cur)
    );

    ebc_seq i_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .split      (split),
        .three      (cfg.three),
        .waits      (cfg.waits),
        .wait_en    (cfg.wait_en),
        .ext_pre    (cfg.ext_pre),
        .ext_post   (cfg.ext_post),
        .ext_wait_n (ext_wait_n),
        .st         (st),
        .beat       (beat),
        .fin        (fin)
    );

    // Half-cycle early read release, timed from the falling edge
    always_ff @(negedge clk) begin
        if (rst) begin
            cut <= 1'b0;
        end else begin
            cut <= fin && !a_we && cfg.rd_early;
        end
    end

    // Read capture at the edge closing the final access clock
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_r <= '0;
        end else if (fin && !a_we) begin
            if (cfg.wide) begin
                rdata_r <= a_wide ? ext_din : {{BYTE_W{1'b0}}, ext_din[BYTE_W-1:0]};
            end else if (beat) begin
                rdata_r[DATA_W-1:BYTE_W] <= ext_din[BYTE_W-1:0];
            end else begin
                rdata_r <= {{BYTE_W{1'b0}}, ext_din[BYTE_W-1:0]};
            end
        end
    end

    // Write lane steering
    always_comb begin
        if (!cfg.wide) begin
            ext_dout = {{BYTE_W{1'b0}},
                        beat ? a_wdata[DATA_W-1:BYTE_W] : a_wdata[BYTE_W-1:0]};
        end else if (a_wide) begin
            ext_dout = a_wdata;
        end else begin
            ext_dout = {{BYTE_W{1'b0}}, a_wdata[BYTE_W-1:0]};
        end
    end

    assign strobe   = st_strobe(st);
    assign ext_addr = a_addr + ADDR_W'(beat);
    assign ext_cs_n = st_on_bus(st) ? ~sel_cur : {AREAS{1'b1}};
    assign ext_rd_n = !(strobe && !a_we && !cut);
    assign ext_wr_n = !(strobe && a_we);
    assign ext_doe  = strobe && a_we;
    assign rdy      = (st == ST_DONE);
    assign rdata    = rdata_r;

endmodule

// File: rtl/ebc_checker.sv
module ebc_checker #(
    parameter int AREAS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rdy,
    input logic [AREAS-1:0] ext_cs_n,
    input logic             ext_rd_n,
    input logic             ext_wr_n
);

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ext_cs_n)); // R1

    AST_CS_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((ext_cs_n != {AREAS{1'b1}}) && ($past(ext_cs_n) != {AREAS{1'b1}}))
        |-> $stable(ext_cs_n)); // R1

    AST_NO_STROBE_CLASH: assert property (@(posedge clk) disable iff (rst)
        !(!ext_rd_n && !ext_wr_n)); // R9

    AST_WR_AFTER_CS: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_wr_n) |-> ($past(ext_cs_n) != {AREAS{1'b1}})); // R9

    AST_RD_AFTER_CS: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_rd_n) |-> ($past(ext_cs_n) != {AREAS{1'b1}})); // R9

    AST_RDY_PULSE: assert property (@(posedge clk) disable iff (rst)
        rdy |=> !rdy); // R10

    AST_RDY_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
        rdy |-> (ext_cs_n == {AREAS{1'b1}})); // R10

endmodule

bind ext_bus_ctrl ebc_checker #(.AREAS(AREAS)) i_ebc_checker (
    .clk      (clk),
    .rst      (rst),
    .rdy      (rdy),
    .ext_cs_n (ext_cs_n),
    .ext_rd_n (ext_rd_n),
    .ext_wr_n (ext_wr_n)
);

// File: tb/test_ext_bus_ctrl.sv
module test_ext_bus_ctrl;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, req_we = 1'b0, req_wide = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rdy;
    logic [15:0] rdata;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_area = '0;
    logic [8:0]  cfg_data = '0;
    logic [23:0] ext_addr;
    logic [7:0]  ext_cs_n;
    logic        ext_rd_n, ext_wr_n, ext_doe;
    logic [15:0] ext_dout, ext_din;
    logic        ext_wait_n = 1'b1;

    int tests = 0, fails = 0;
    int cs_cnt, rd_half, wr_cyc, rdy_cnt, cs_bad, wn, wait_rel;
    bit mon_on = 0, prev_wr = 1;
    logic [2:0]  area_exp;
    logic [39:0] wrec [4];
    logic [15:0] rd_val;

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] mb(input logic [23:0] a);
        return a[7:0] ^ 8'h3C ^ {5'd0, a[23:21]};
    endfunction

    assign ext_din = {~mb(ext_addr), mb(ext_addr)};

    ext_bus_ctrl i_ext_bus_ctrl (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata), .rdy(rdy), .rdata(rdata),
        .cfg_we(cfg_we), .cfg_area(cfg_area), .cfg_data(cfg_data),
        .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_doe(ext_doe), .ext_dout(ext_dout),
        .ext_din(ext_din), .ext_wait_n(ext_wait_n)
    );

    // first-half sample of each clock
    always @(posedge clk) begin
        #1;
        if (mon_on && !ext_rd_n) rd_half++;
    end

    // second-half sample of each clock
    always @(negedge clk) begin
        #1;
        if (mon_on) begin
            if (ext_cs_n != 8'hFF) begin
                cs_cnt++;
                if (ext_cs_n != ~(8'b1 << area_exp)) cs_bad++;
                if (!ext_rd_n || !ext_wr_n) begin end
            end
            if (!ext_rd_n) rd_half++;
            if (!ext_wr_n) begin
                wr_cyc++;
                if (!ext_doe) cs_bad++;
                if (prev_wr && wn < 4) begin
                    wrec[wn] = {ext_addr, ext_dout};
                    wn++;
                end
            end
            prev_wr = ext_wr_n;
            if (rdy) rdy_cnt++;
            if (wait_rel != 0 && cs_cnt == wait_rel) ext_wait_n = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] ar, input logic [8:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_area = ar; cfg_data = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_mon(input logic [2:0] ar);
        area_exp = ar; cs_cnt = 0; rd_half = 0; wr_cyc = 0;
        rdy_cnt = 0; cs_bad = 0; wn = 0; prev_wr = 1;
    endtask

    task automatic wait_rdy();
        bit got = 0;
        for (int k = 0; k < 300 && !got; k++) begin
            #2;
            if (rdy) begin
                got = 1;
                rd_val = rdata;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        @(negedge clk);
        #2;
        mon_on = 0;
    endtask

    task automatic run_op(input logic [2:0] ar, input logic [23:0] a,
                          input logic we, input logic wide, input logic [15:0] wd);
        clear_mon(ar);
        @(negedge clk);
        req = 1'b1; req_we = we; req_wide = wide; req_addr = a; req_wdata = wd;
        mon_on = 1;
        @(negedge clk);
        req = 1'b0;
        wait_rdy();
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        // R1 R10: idle outputs after reset
        chk(ext_cs_n == 8'hFF, "R1 idle cs", ext_cs_n, 8'hFF);
        chk(ext_rd_n && ext_wr_n && !ext_doe, "R9 idle strobes", {ext_rd_n, ext_wr_n}, 3);
        chk(!rdy, "R10 idle rdy", rdy, 0);

        // R11: reset settings, wide read on area 7
        run_op(3'd7, {3'd7, 21'h000040}, 1'b0, 1'b1, 16'h0);
        chk(cs_cnt == 10, "R11 default cs clocks", cs_cnt, 10);
        chk(rd_val == {~mb({3'd7, 21'h40}), mb({3'd7, 21'h40})}, "R11 default rdata",
            rd_val, {~mb({3'd7, 21'h40}), mb({3'd7, 21'h40})});

        // R12: settings write during a transaction is dropped
        clear_mon(3'd6);
        @(negedge clk);
        req = 1'b1; req_we = 1'b0; req_wide = 1'b1; req_addr = {3'd6, 21'h10};
        mon_on = 1;
        @(negedge clk);
        req = 1'b0; cfg_we = 1'b1; cfg_area = 3'd6; cfg_data = 9'h001;
        @(negedge clk);
        cfg_we = 1'b0;
        wait_rdy();
        run_op(3'd6, {3'd6, 21'h10}, 1'b0, 1'b1, 16'h0);
        chk(cs_cnt == 10, "R12 busy write dropped", cs_cnt, 10);
        set_cfg(3'd6, 9'h001);
        run_op(3'd6, {3'd6, 21'h10}, 1'b0, 1'b1, 16'h0);
        chk(cs_cnt == 2, "R12 idle write taken", cs_cnt, 2);

        // R2..R10 sweep over width, states, extensions, waits and direction
        for (int n = 0; n < 96; n++) begin
            int wdt = n % 2;
            int th  = (n / 2) % 2;
            int ex  = (n / 4) % 4;
            int wi  = (n / 16) % 3;
            int we  = n / 48;
            int wt  = (wi == 0) ? 0 : (wi == 1) ? 2 : 7;
            int pre = ex % 2;
            int pst = ex / 2;
            int rde = (ex % 2) ^ th;
            bit wide = (wi != 1);
            int nb   = (wide && wdt == 0) ? 2 : 1;
            int s    = (th != 0) ? 2 + wt : 1;
            int ecs  = nb * (pre + pst + ((th != 0) ? 3 + wt : 2));
            logic [2:0]  ar = 3'(n);
            logic [23:0] a  = {ar, 13'd0, 7'(n), 1'b0};
            logic [15:0] wd = 16'(n * 16'h0B3D + 16'h1234);
            logic [15:0] exp_rd;
            logic [15:0] lo, hi;
            set_cfg(ar, {1'(rde), 1'(pst), 1'(pre), 1'b0, 3'(wt), 1'(th), 1'(wdt)});
            run_op(ar, a, 1'(we), wide, wd);
            chk(cs_cnt == ecs, (th != 0) ? "R5 R7 cs clocks" : "R4 R7 cs clocks", cs_cnt, ecs);
            chk(cs_bad == 0, "R1 cs select", cs_bad, 0);
            chk(rdy_cnt == 1, "R10 rdy pulse", rdy_cnt, 1);
            if (we == 0) begin
                if (!wide) exp_rd = {8'h00, mb(a)};
                else if (wdt == 1) exp_rd = {~mb(a), mb(a)};
                else exp_rd = {mb(a + 24'd1), mb(a)};
                chk(rd_val == exp_rd, "R2 R3 read data", rd_val, exp_rd);
                chk(rd_half == nb * (2 * s - rde), "R8 rd half-clocks", rd_half, nb * (2 * s - rde));
                chk(wr_cyc == 0, "R9 no wr on read", wr_cyc, 0);
            end else begin
                chk(wr_cyc == nb * s, "R9 wr clocks", wr_cyc, nb * s);
                chk(rd_half == 0, "R9 no rd on write", rd_half, 0);
                chk(wn == nb, "R3 write beats", wn, nb);
                lo = (wide && wdt == 1) ? wd : {8'h00, wd[7:0]};
                chk(wrec[0] == {a, lo}, "R2 R3 first beat", wrec[0][31:0], {a[15:0], lo});
                if (nb == 2) begin
                    hi = {8'h00, wd[15:8]};
                    chk(wrec[1] == {a + 24'd1, hi}, "R3 second beat",
                        wrec[1][31:0], {a[15:0] + 16'd1, hi});
                end
            end
        end

        // R6: wait pin, waits=1, released after clock 6 -> 7 clocks
        set_cfg(3'd2, 9'b0_0010_0111);
        ext_wait_n = 1'b0; wait_rel = 6;
        run_op(3'd2, {3'd2, 21'h20}, 1'b0, 1'b1, 16'h0);
        chk(cs_cnt == 7, "R6 pin extends", cs_cnt, 7);
        // R6: released before sampling point -> no extra
        ext_wait_n = 1'b0; wait_rel = 2;
        run_op(3'd2, {3'd2, 21'h20}, 1'b0, 1'b1, 16'h0);
        chk(cs_cnt == 4, "R6 early release", cs_cnt, 4);
        // R6: waits=0, sampled in second clock, released after clock 5 -> 6
        set_cfg(3'd2, 9'b0_0010_0011);
        ext_wait_n = 1'b0; wait_rel = 5;
        run_op(3'd2, {3'd2, 21'h20}, 1'b0, 1'b1, 16'h0);
        chk(cs_cnt == 6, "R6 zero waits pin", cs_cnt, 6);
        // R6: pin disabled -> ignored
        set_cfg(3'd2, 9'b0_0000_0111);
        ext_wait_n = 1'b0; wait_rel = 6;
        run_op(3'd2, {3'd2, 21'h20}, 1'b0, 1'b1, 16'h0);
        chk(cs_cnt == 4, "R6 pin disabled", cs_cnt, 4);
        // R4: two-state area ignores enabled pin
        set_cfg(3'd2, 9'b0_0010_0101);
        ext_wait_n = 1'b0; wait_rel = 6;
        run_op(3'd2, {3'd2, 21'h20}, 1'b0, 1'b1, 16'h0);
        chk(cs_cnt == 2, "R4 two-state ignores pin", cs_cnt, 2);
        ext_wait_n = 1'b1; wait_rel = 0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule